// File: doc/BRIEF.md
# Dual Palette Lookup Store

This block keeps two 256-entry color palettes, one for foreground pixels and one for background pixels. Software loads them through a 32-bit write-only slave port. Each palette has its own window in the slave address space. A per-palette format bit chooses how incoming bus bytes are laid out. In the 32-bit format every bus word is one full alpha/red/green/blue entry. In the packed 24-bit format, entries are three bytes long and sit back to back, so a single bus word can finish one entry and start the next.

Each palette has a read port. It takes an 8-bit pixel index and returns the 32-bit alpha/red/green/blue color one clock later. When a palette is in the 24-bit format, alpha is reported as fully opaque.

An external busy input marks a window in which the palettes must not be touched. A write into either palette window while busy is high is thrown away. It also raises a sticky access-error flag, and that flag drives an interrupt output when interrupts are enabled.

Top module: `clut_pair_store`

## Requirements
- R1: Byte addresses 0x400 to 0x7FF select the foreground palette and 0x800 to 0xBFF select the background palette. A write to any other address changes no entry and raises no error.
- R2: In the 32-bit format (format bit 0), the word at palette byte offset o writes entry o/4. The lanes map as bits [7:0] = blue, [15:8] = green, [23:16] = red, [31:24] = alpha. The read result is laid out as {alpha, red, green, blue}, with alpha in bits [31:24] and blue in bits [7:0].
- R3: In the 24-bit format (format bit 1), lane l of the word at offset o is the palette byte b = o + l. That byte goes to entry b/3 as blue when b mod 3 is 0, green when it is 1, and red when it is 2. Bytes with b of 768 or more are dropped.
- R4: A palette in the 24-bit format returns 0xFF in bits [31:24] of its read result.
- R5: Only lanes whose byte-enable bit is 1 update the component they address. All other components of the touched entries keep their values.
- R6: The read result shows the entry whose index was present at the previous rising clock edge. A change of index between edges does not alter the output.
- R7: A palette write while busy is 1 changes no entry, and the error flag is 1 after that clock edge. A busy write outside both palette windows does not set the flag.
- R8: The error flag stays 1 until err_clr is 1 at a clock edge. If a blocked write and err_clr arrive together, the flag stays set.
- R9: irq is 1 exactly when the error flag is 1 and irq_en is 1.
- R10: During reset both read outputs, the error flag and irq are 0.
- R11: The two palettes use their format bits independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Slave write strobe |
| bus_addr | input | 12 | Byte address, word aligned |
| bus_be | input | 4 | Byte-lane enables |
| bus_wdata | input | 32 | Write data |
| fg_rgb24 | input | 1 | Foreground format: 0 = 32-bit, 1 = packed 24-bit |
| bg_rgb24 | input | 1 | Background format: 0 = 32-bit, 1 = packed 24-bit |
| busy | input | 1 | Palettes locked; writes into them are refused |
| err_clr | input | 1 | Clears the access-error flag |
| irq_en | input | 1 | Interrupt enable |
| fg_idx | input | 8 | Foreground pixel index |
| bg_idx | input | 8 | Background pixel index |
| fg_argb | output | 32 | Foreground color, registered |
| bg_argb | output | 32 | Background color, registered |
| acc_err | output | 1 | Sticky access-error flag |
| irq | output | 1 | Interrupt request |

## Verification
The hardest cases to reach from the ports are the packed 24-bit writes that split across a word boundary.

The first is the last bus word of a palette window. It completes entry 254 and fills entry 255. The second is the word just past byte 767. With a truncated entry number that word would wrap onto entry 0. The stimulus loads three consecutive words and the last in-range word, then writes a word at offset 0x300, and finally reads entry 0 back to confirm that nothing wrapped.

A single-lane write into the middle word checks that the enables reach one component of one straddled entry. A blocked write issued together with err_clr exercises the set-over-clear priority.

// File: rtl/clut_pkg.sv
package clut_pkg;
  localparam int CLUT_DEPTH = 256;
  localparam int IDX_W      = $clog2(CLUT_DEPTH);
  localparam int OFF_W      = IDX_W + 2;
  localparam int LANES      = 4;
  localparam int PACK_BYTES = 3 * CLUT_DEPTH;

  typedef enum logic [1:0] {PL_B = 2'd0, PL_G = 2'd1, PL_R = 2'd2, PL_A = 2'd3} plane_e;

  typedef struct packed {
    logic             ok;
    logic [IDX_W-1:0] entry;
    plane_e           plane;
  } slot_t;

  // Where one byte lane of a word lands inside a palette.
  function automatic slot_t lane_slot(input logic rgb24,
                                      input logic [OFF_W-1:0] word_off,
                                      input logic [1:0] lane);
    logic [OFF_W:0] bo;
    slot_t s;
    bo = {1'b0, word_off} + (OFF_W+1)'(lane);
    if (rgb24) begin
      s.ok    = (bo < (OFF_W+1)'(PACK_BYTES));
      s.entry = IDX_W'(bo / (OFF_W+1)'(3));
      s.plane = plane_e'(2'(bo % (OFF_W+1)'(3)));
    end else begin
      s.ok    = 1'b1;
      s.entry = word_off[OFF_W-1:2];
      s.plane = plane_e'(lane);
    end
    return s;
  endfunction

  // Assemble the read result; packed format reports opaque alpha.
  function automatic logic [31:0] expand_argb(input logic rgb24, input logic [7:0] a,
                                              input logic [7:0] r, input logic [7:0] g,
                                              input logic [7:0] b);
    return {(rgb24 ? 8'hFF : a), r, g, b};
  endfunction
endpackage

// File: rtl/clut_bus_decode.sv
module clut_bus_decode
  import clut_pkg::*;
#(
  parameter int              ADDR_W  = 12,
  parameter logic [ADDR_W-1:0] FG_BASE = 12'h400,
  parameter logic [ADDR_W-1:0] BG_BASE = 12'h800
) (
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [LANES-1:0]  bus_be,
  input  logic              busy,
  input  logic              fg_rgb24,
  input  logic              bg_rgb24,
  output slot_t             lane_slots [LANES],
  output logic [LANES-1:0]  fg_we,
  output logic [LANES-1:0]  bg_we,
  output logic              blocked
);
  localparam int REGION = LANES * CLUT_DEPTH;
  localparam logic [ADDR_W:0] FG_END = {1'b0, FG_BASE} + (ADDR_W+1)'(REGION);
  localparam logic [ADDR_W:0] BG_END = {1'b0, BG_BASE} + (ADDR_W+1)'(REGION);

  logic             fg_hit, bg_hit, sel_mode;
  logic [OFF_W-1:0] sel_off, word_off;
  logic [ADDR_W-1:0] fg_diff, bg_diff;

  assign fg_hit   = bus_wr && (bus_addr >= FG_BASE) && ({1'b0, bus_addr} < FG_END);
  assign bg_hit   = bus_wr && (bus_addr >= BG_BASE) && ({1'b0, bus_addr} < BG_END);
  assign blocked  = (fg_hit || bg_hit) && busy;
  assign sel_mode = fg_hit ? fg_rgb24 : bg_rgb24;
  assign fg_diff  = bus_addr - FG_BASE;
  assign bg_diff  = bus_addr - BG_BASE;
  assign sel_off  = fg_hit ? fg_diff[OFF_W-1:0] : bg_diff[OFF_W-1:0];
  assign word_off = sel_off & ~OFF_W'(3);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lane_slots[l] = lane_slot(sel_mode, word_off, 2'(l));
    assign fg_we[l] = fg_hit && !busy && bus_be[l] && lane_slots[l].ok;
    assign bg_we[l] = bg_hit && !busy && bus_be[l] && lane_slots[l].ok;
  end
endmodule

// File: rtl/clut_palette.sv
module clut_palette
  import clut_pkg::*;
#(
  parameter int DEPTH = CLUT_DEPTH
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rgb24,
  input  logic [LANES-1:0]     lane_we,
  input  slot_t                lane_slots [LANES],
  input  logic [LANES*8-1:0]   wdata,
  input  logic [IDX_W-1:0]     rd_idx,
  output logic [31:0]          rd_argb
);
  logic mode_q;

  for (genvar p = 0; p < 4; p++) begin : g_plane
    logic [7:0] mem [DEPTH];
    logic [7:0] q;
    always_ff @(posedge clk) begin
      for (int l = 0; l < LANES; l++) begin
        if (lane_we[l] && lane_slots[l].plane == plane_e'(2'(p)))
          mem[lane_slots[l].entry] <= wdata[l*8 +: 8];
      end
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= mem[rd_idx];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= 1'b0;
    else        mode_q <= rgb24;
  end

  assign rd_argb = expand_argb(mode_q, g_plane[3].q, g_plane[2].q,
                               g_plane[1].q, g_plane[0].q);
endmodule

// File: rtl/clut_err_flag.sv
module clut_err_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic clr,
  input  logic irq_en,
  output logic acc_err,
  output logic irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       acc_err <= 1'b0;
    else if (set_evt) acc_err <= 1'b1;
    else if (clr)     acc_err <= 1'b0;
  end
  assign irq = acc_err & irq_en;
endmodule

// File: rtl/clut_pair_store.sv
module clut_pair_store
  import clut_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic [11:0] bus_addr,
  input  logic [3:0]  bus_be,
  input  logic [31:0] bus_wdata,
  input  logic        fg_rgb24,
  input  logic        bg_rgb24,
  input  logic        busy,
  input  logic        err_clr,
  input  logic        irq_en,
  input  logic [7:0]  fg_idx,
  input  logic [7:0]  bg_idx,
  output logic [31:0] fg_argb,
  output logic [31:0] bg_argb,
  output logic        acc_err,
  output logic        irq
);
  slot_t            lane_slots [LANES];
  logic [LANES-1:0] fg_lane_we, bg_lane_we;
  logic             blk_evt;

  clut_bus_decode #(.ADDR_W(12), .FG_BASE(12'h400), .BG_BASE(12'h800)) u_dec (
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_be(bus_be), .busy(busy),
    .fg_rgb24(fg_rgb24), .bg_rgb24(bg_rgb24), .lane_slots(lane_slots),
    .fg_we(fg_lane_we), .bg_we(bg_lane_we), .blocked(blk_evt)
  );

  clut_palette #(.DEPTH(CLUT_DEPTH)) u_fg (
    .clk(clk), .rst_n(rst_n), .rgb24(fg_rgb24), .lane_we(fg_lane_we),
    .lane_slots(lane_slots), .wdata(bus_wdata), .rd_idx(fg_idx), .rd_argb(fg_argb)
  );

  clut_palette #(.DEPTH(CLUT_DEPTH)) u_bg (
    .clk(clk), .rst_n(rst_n), .rgb24(bg_rgb24), .lane_we(bg_lane_we),
    .lane_slots(lane_slots), .wdata(bus_wdata), .rd_idx(bg_idx), .rd_argb(bg_argb)
  );

  clut_err_flag u_err (
    .clk(clk), .rst_n(rst_n), .set_evt(blk_evt), .clr(err_clr),
    .irq_en(irq_en), .acc_err(acc_err), .irq(irq)
  );
endmodule

// File: rtl/clut_pair_store_chk.sv
module clut_pair_store_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_wr,
  input logic        err_clr,
  input logic        irq_en,
  input logic        blocked,
  input logic [3:0]  fg_we,
  input logic [3:0]  bg_we,
  input logic        acc_err,
  input logic        irq,
  input logic        fg_rgb24,
  input logic        bg_rgb24,
  input logic [31:0] fg_argb,
  input logic [31:0] bg_argb
);
  // R1
  one_palette_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({|fg_we, |bg_we}));
  // R1
  idle_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |-> (fg_we == 4'b0 && bg_we == 4'b0));
  // R7
  blocked_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blocked |-> (fg_we == 4'b0 && bg_we == 4'b0));
  // R7
  blocked_sets_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blocked |=> acc_err);
  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_err && !err_clr) |=> acc_err);
  // R8
  err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_clr && !blocked) |=> !acc_err);
  // R9
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !irq);
  // R9
  irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_err && irq_en) |-> irq);
  // R4
  fg_alpha_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fg_rgb24 |=> fg_argb[31:24] == 8'hFF);
  // R4
  bg_alpha_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bg_rgb24 |=> bg_argb[31:24] == 8'hFF);
endmodule

bind clut_pair_store clut_pair_store_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .err_clr(err_clr), .irq_en(irq_en),
  .blocked(blk_evt), .fg_we(fg_lane_we), .bg_we(bg_lane_we), .acc_err(acc_err),
  .irq(irq), .fg_rgb24(fg_rgb24), .bg_rgb24(bg_rgb24), .fg_argb(fg_argb),
  .bg_argb(bg_argb)
);

// File: tb/tb_clut_pair_store.sv
module tb_clut_pair_store;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 20;
  // {req[3:0], op[1:0] (0 write, 1 check fg, 2 check bg), addr[11:0], be[3:0], data[31:0]}
  localparam logic [53:0] VEC [NV] = '{
    {4'd2,  2'd0, 12'h404, 4'hF, 32'h80112233},
    {4'd2,  2'd0, 12'h7FC, 4'hF, 32'hDEADBEEF},
    {4'd5,  2'd0, 12'h408, 4'hF, 32'h01020304},
    {4'd5,  2'd0, 12'h408, 4'h5, 32'h44556677},
    {4'd3,  2'd0, 12'h800, 4'hF, 32'h40302010},
    {4'd3,  2'd0, 12'h804, 4'hF, 32'h80706050},
    {4'd3,  2'd0, 12'h808, 4'hF, 32'hC0B0A090},
    {4'd3,  2'd0, 12'hAFC, 4'hF, 32'h332211EE},
    {4'd3,  2'd0, 12'hB00, 4'hF, 32'hFFFFFFFF},
    {4'd5,  2'd0, 12'h804, 4'h2, 32'h0000AB00},
    {4'd1,  2'd0, 12'h004, 4'hF, 32'h99999999},
    {4'd1,  2'd0, 12'hC04, 4'hF, 32'h99999999},
    {4'd2,  2'd1, 12'h001, 4'h0, 32'h80112233},  // R2 plain entry, R1 outside writes ignored
    {4'd2,  2'd1, 12'h0FF, 4'h0, 32'hDEADBEEF},  // R2 last word of window
    {4'd5,  2'd1, 12'h002, 4'h0, 32'h01550377},  // R5 lanes 0 and 2 only
    {4'd3,  2'd2, 12'h000, 4'h0, 32'hFF302010},  // R3 and no wrap from byte 768
    {4'd5,  2'd2, 12'h001, 4'h0, 32'hFFAB5040},  // R5 single red lane of straddled entry
    {4'd3,  2'd2, 12'h002, 4'h0, 32'hFF908070},  // R3 entry split over two words
    {4'd3,  2'd2, 12'h003, 4'h0, 32'hFFC0B0A0},  // R3 third word
    {4'd11, 2'd2, 12'h0FF, 4'h0, 32'hFF332211}   // R11 bg packed while fg is 32-bit; R3 last entry
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_wr = 1'b0, fg_rgb24 = 1'b0, bg_rgb24 = 1'b0, busy = 1'b0, err_clr = 1'b0, irq_en = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_wdata = '0;
  logic [7:0]  fg_idx = '0, bg_idx = '0;
  logic [31:0] fg_argb, bg_argb;
  logic acc_err, irq;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  clut_pair_store dut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [3:0] b, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_be = b; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_be = '0;
  endtask

  task automatic rd(input logic [7:0] fi, input logic [7:0] bi);
    @(negedge clk);
    fg_idx = fi; bg_idx = bi;
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 fg_argb", fg_argb, 32'h0);
    chk("R10 bg_argb", bg_argb, 32'h0);
    chk("R10 acc_err", {31'b0, acc_err}, 32'h0);
    chk("R10 irq", {31'b0, irq}, 32'h0);
    rst_n = 1'b1;
    fg_rgb24 = 1'b0; bg_rgb24 = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [53:0] v;
      v = VEC[i];
      if (v[49:48] == 2'd0) wr(v[47:36], v[35:32], v[31:0]);
      else begin
        rd(v[43:36], v[43:36]);
        if (v[49:48] == 2'd1) chk($sformatf("R%0d vec %0d fg", v[53:50], i), fg_argb, v[31:0]);
        else                  chk($sformatf("R%0d vec %0d bg", v[53:50], i), bg_argb, v[31:0]);
      end
    end

    // R6 one-cycle latency
    rd(8'd1, 8'd0);
    @(negedge clk); fg_idx = 8'd255; #1;
    chk("R6 before edge", fg_argb, 32'h80112233);
    @(negedge clk);
    chk("R6 after edge", fg_argb, 32'hDEADBEEF);

    // R4 / R11 switch fg to packed format: alpha forced
    fg_rgb24 = 1'b1;
    rd(8'd1, 8'd0);
    chk("R4 fg alpha", fg_argb, 32'hFF112233);
    chk("R11 bg unaffected", bg_argb, 32'hFF302010);
    fg_rgb24 = 1'b0;

    // R7 blocked write
    busy = 1'b1;
    wr(12'h404, 4'hF, 32'h00000000);
    chk("R7 err set", {31'b0, acc_err}, 32'h1);
    chk("R9 irq off while disabled", {31'b0, irq}, 32'h0);
    busy = 1'b0;
    rd(8'd1, 8'd0);
    chk("R7 entry kept", fg_argb, 32'h80112233);
    chk("R8 sticky", {31'b0, acc_err}, 32'h1);
    irq_en = 1'b1; #1;
    chk("R9 irq on", {31'b0, irq}, 32'h1);
    @(negedge clk); err_clr = 1'b1;
    @(negedge clk); err_clr = 1'b0;
    chk("R8 cleared", {31'b0, acc_err}, 32'h0);
    chk("R9 irq follows clear", {31'b0, irq}, 32'h0);

    // R8 set wins over clear
    @(negedge clk);
    busy = 1'b1; err_clr = 1'b1; bus_wr = 1'b1; bus_addr = 12'h800; bus_be = 4'hF; bus_wdata = 32'h0;
    @(negedge clk);
    bus_wr = 1'b0; err_clr = 1'b0;
    chk("R8 set beats clear", {31'b0, acc_err}, 32'h1);
    rd(8'd1, 8'd0);
    chk("R7 bg kept", bg_argb, 32'hFF302010);
    @(negedge clk); err_clr = 1'b1;
    @(negedge clk); err_clr = 1'b0;

    // R7 busy write outside windows
    wr(12'h100, 4'hF, 32'h12345678);
    chk("R7 outside no err", {31'b0, acc_err}, 32'h0);
    busy = 1'b0;

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule